// File: doc/BRIEF.md
# Mailbox Request/Response Sequencer

This block runs one complete requester-side exchange over a 256-bit shared mailbox aperture. The aperture is organised as eight 32-bit words, and word 7 is the control header. A command either establishes a set of four queues or destroys it. An establish command carries four 52-bit page-frame numbers (event, completion, receive and send queue, in that order), an interrupt vector and a reset flag. A destroy command carries only the reset flag.

Once it accepts a command, the sequencer first waits until the requester owns the aperture. It does this by reading the header word once per poll-tick input until the owner bit is clear. It then writes the packed message and polls the header again until ownership comes back. Last, it judges the response. The result is a one-cycle done pulse with a 2-bit result code: 0 success, 1 timeout, 2 protocol error, 3 rejected command. Each polling phase gives up after a parameterised number of reads, 20000 by default, and that count restarts for each phase.

Top module: `mbx_req_seq`

## Requirements
- R1: While waiting to send, the block reads only word 7, at most one read per cycle in which `poll_tick` is high. It repeats until a read returns bit 31 clear, and it writes nothing in the meantime.
- R2: If MAX_POLLS reads in the pre-send phase all return bit 31 set, the block finishes with result 1 and performs no write.
- R3: For an establish command, frame number q (q = 0..3) has its bits [47:0] placed little-endian at message bytes 6q..6q+5. Message byte k lies in word k/4, bits 8*(k%4)+7 down to 8*(k%4).
- R4: For an establish command, bits [51:48] of frame number q are placed at message bits 192+4q+3..192+4q, which are bytes 24-25.
- R5: For an establish command, `cmd_vector[15:0]` is placed at bytes 26-27. If any bit of `cmd_vector[31:16]` is set, the command finishes with result 3 and causes no mailbox access. A destroy command ignores the vector.
- R6: The header word written to word 7 has the type in bits [2:0] (1 establish, 2 destroy), version 0 in bits [5:3] and direction 0 in bit 7. It has status 0 in bits [15:8], the reset flag in bit 24, and zero in all other bits, including owner bit 31.
- R7: An establish writes words 0 through 7 on consecutive cycles in ascending order. A destroy writes word 7 only.
- R8: After the header write, the block polls word 7 once per `poll_tick`, with a fresh count of MAX_POLLS reads. If every read returns bit 31 set, the block finishes with result 1.
- R9: A response read with bit 31 clear is accepted only when all of the following hold: its type equals the requested type, its version bits [5:3] do not exceed the requested version 0, bit 7 is 1 and bits [15:8] are 0. An accepted response gives result 0, and any other response gives result 2.
- R10: When the reset flag of the command was 1, a response-phase read of 0xFFFFFFFF finishes at once with result 0. When the flag was 0, that value counts as still owned.
- R11: `done` is high for exactly one cycle per accepted command, and `busy` stays high from the cycle after acceptance through the done cycle. `cmd_valid` while busy is ignored.
- R12: After reset the block is idle: `busy`, `done`, `mb_rd_en` and `mb_wr_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start a command (taken when idle) |
| cmd_op | input | 1 | 0 establish, 1 destroy |
| cmd_reset | input | 1 | Reset flag carried in the header |
| cmd_pfns | input | 208 | Four 52-bit frame numbers, queue 0 in the low bits |
| cmd_vector | input | 32 | Interrupt vector; must fit in 16 bits |
| poll_tick | input | 1 | Poll-interval pulse |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Result code, valid with done |
| mb_rd_en | output | 1 | Mailbox read strobe |
| mb_wr_en | output | 1 | Mailbox write strobe |
| mb_addr | output | 3 | Mailbox word index |
| mb_wdata | output | 32 | Mailbox write data |
| mb_rdata | input | 32 | Mailbox read data, valid the cycle after a read |

## Verification
A wrong controller state shows up within one cycle as a strobe the reference does not expect: a read without a tick, a write before ownership, or writes out of order. A packing or header fault corrupts the very write word it belongs to, so it is caught in the cycle of that write. Counter or verdict faults change the number of reads seen in a phase, or the result code, and these are compared at the done pulse, a few ticks after the decisive read.

// File: rtl/mbx_req_pkg.sv
package mbx_req_pkg;

   typedef enum logic [2:0] {
      S_IDLE, S_PRE_REQ, S_PRE_CHK, S_WRITE, S_RSP_REQ, S_RSP_CHK, S_FIN
   } seq_state_t;

   typedef enum logic [1:0] {
      RES_OK = 2'd0, RES_TIMEOUT = 2'd1, RES_PROTO = 2'd2, RES_REJECT = 2'd3
   } seq_res_t;

   localparam logic OP_ESTABLISH = 1'b0;
   localparam logic OP_DESTROY   = 1'b1;

   localparam logic [2:0] TYPE_ESTABLISH = 3'd1;
   localparam logic [2:0] TYPE_DESTROY   = 3'd2;
   localparam logic [2:0] VER_REQUEST    = 3'd0;

   // header word layout, bit 31 down to bit 0
   typedef struct packed {
      logic       owner;
      logic [5:0] rsv_hi;
      logic       reset;
      logic [7:0] rsv_mid;
      logic [7:0] status;
      logic       dir;
      logic       rsv_lo;
      logic [2:0] ver;
      logic [2:0] mtype;
   } mbx_hdr_t;

   function automatic mbx_hdr_t make_request(input logic [2:0] mtype, input logic rflag);
      mbx_hdr_t h;
      h       = '0;
      h.mtype = mtype;
      h.ver   = VER_REQUEST;
      h.reset = rflag;
      return h;
   endfunction

endpackage

// File: rtl/mbx_req_pack.sv
module mbx_req_pack
   import mbx_req_pkg::*;
#(
   parameter int NQ    = 4,
   parameter int PFN_W = 52,
   parameter int LOW_W = 48,
   parameter int VEC_W = 16,
   parameter int DW    = 32,
   parameter int WORDS = 8
) (
   input  logic [NQ*PFN_W-1:0]       pfns,
   input  logic [VEC_W-1:0]          vec,
   input  mbx_hdr_t                  hdr,
   input  logic [$clog2(WORDS)-1:0]  idx,
   output logic [DW-1:0]             word
);
   localparam int HI_W    = PFN_W - LOW_W;
   localparam int HI_BASE = NQ * LOW_W;
   localparam int VEC_POS = HI_BASE + NQ * HI_W;
   localparam int HDR_POS = (WORDS - 1) * DW;
   localparam int MSG_W   = WORDS * DW;

   if (VEC_POS + VEC_W > HDR_POS) begin : g_bad_fit
      initial $error("mbx_req_pack: payload does not fit below the header word");
   end
   if (HI_W < 1) begin : g_bad_split
      initial $error("mbx_req_pack: frame number must be wider than its low part");
   end

   logic [MSG_W-1:0] msg;
   logic [NQ*LOW_W-1:0] low_field;
   logic [NQ*HI_W-1:0]  hi_field;

   for (genvar q = 0; q < NQ; q++) begin : g_queue
      assign low_field[q*LOW_W +: LOW_W] = pfns[q*PFN_W +: LOW_W];
      assign hi_field[q*HI_W +: HI_W]    = pfns[q*PFN_W + LOW_W +: HI_W];
   end

   always_comb begin
      msg = '0;
      msg[0 +: NQ*LOW_W]       = low_field;
      msg[HI_BASE +: NQ*HI_W]  = hi_field;
      msg[VEC_POS +: VEC_W]    = vec;
      msg[HDR_POS +: DW]       = hdr;
   end

   assign word = msg[idx*DW +: DW];

endmodule

// File: rtl/mbx_req_pollcnt.sv
module mbx_req_pollcnt #(
   parameter int MAX_POLLS = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic inc,
   output logic expired
);
   localparam int CW = $clog2(MAX_POLLS + 1);
   localparam logic [CW-1:0] LIMIT = CW'(MAX_POLLS);

   if (MAX_POLLS < 1) begin : g_bad_limit
      initial $error("mbx_req_pollcnt: MAX_POLLS must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clear)         cnt_q <= '0;
      else if (inc && !expired) cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q >= LIMIT);

endmodule

// File: rtl/mbx_req_verdict.sv
module mbx_req_verdict
   import mbx_req_pkg::*;
#(
   parameter bit ALLOW_OLDER = 1'b1
) (
   input  logic [31:0] rdata,
   input  logic [2:0]  exp_type,
   input  logic        rflag,
   output logic        owned,
   output logic        forced_ok,
   output logic        accept
);
   mbx_hdr_t h;
   logic     ver_ok;
   logic     unused_bits;

   assign h         = rdata;
   assign owned     = h.owner;
   assign forced_ok = rflag && (rdata == 32'hFFFF_FFFF);

   if (ALLOW_OLDER) begin : g_ver_le
      assign ver_ok = (h.ver <= VER_REQUEST);
   end else begin : g_ver_eq
      assign ver_ok = (h.ver == VER_REQUEST);
   end

   assign accept = (h.mtype == exp_type) && ver_ok && h.dir && (h.status == 8'd0);
   assign unused_bits = ^{h.rsv_hi, h.reset, h.rsv_mid, h.rsv_lo};

endmodule

// File: rtl/mbx_req_seq.sv
module mbx_req_seq
   import mbx_req_pkg::*;
#(
   parameter int NQ          = 4,
   parameter int PFN_W       = 52,
   parameter int LOW_W       = 48,
   parameter int VEC_W       = 16,
   parameter int VEC_IN_W    = 32,
   parameter int DW          = 32,
   parameter int WORDS       = 8,
   parameter int MAX_POLLS   = 20000,
   parameter bit ALLOW_OLDER = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmd_valid,
   input  logic                     cmd_op,
   input  logic                     cmd_reset,
   input  logic [NQ*PFN_W-1:0]      cmd_pfns,
   input  logic [VEC_IN_W-1:0]      cmd_vector,
   input  logic                     poll_tick,
   output logic                     busy,
   output logic                     done,
   output logic [1:0]               result,
   output logic                     mb_rd_en,
   output logic                     mb_wr_en,
   output logic [$clog2(WORDS)-1:0] mb_addr,
   output logic [DW-1:0]            mb_wdata,
   input  logic [DW-1:0]            mb_rdata
);
   localparam int IDX_W = $clog2(WORDS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

   if (DW != 32) begin : g_bad_dw
      initial $error("mbx_req_seq: header word must be 32 bits");
   end
   if (VEC_IN_W < VEC_W) begin : g_bad_vec
      initial $error("mbx_req_seq: vector input narrower than vector field");
   end

   seq_state_t           st_q, st_d;
   seq_res_t             res_q, res_d;
   logic [IDX_W-1:0]     widx_q, widx_d;
   logic                 op_q, rflag_q;
   logic [NQ*PFN_W-1:0]  pfns_q;
   logic [VEC_W-1:0]     vec_q;
   logic                 latch, cnt_clr, cnt_inc, cnt_exp;
   logic                 vec_over;
   logic                 rsp_owned, rsp_forced, rsp_accept;
   logic [2:0]           req_type;
   mbx_hdr_t             req_hdr;
   logic [DW-1:0]        pack_word;

   // vector range check: variant chosen by the input width
   if (VEC_IN_W > VEC_W) begin : g_vec_chk
      assign vec_over = |cmd_vector[VEC_IN_W-1:VEC_W];
   end else begin : g_vec_fit
      assign vec_over = 1'b0;
   end

   assign req_type = (op_q == OP_ESTABLISH) ? TYPE_ESTABLISH : TYPE_DESTROY;
   assign req_hdr  = make_request(req_type, rflag_q);

   mbx_req_pack #(
      .NQ(NQ), .PFN_W(PFN_W), .LOW_W(LOW_W), .VEC_W(VEC_W), .DW(DW), .WORDS(WORDS)
   ) u_pack (
      .pfns (pfns_q),
      .vec  (vec_q),
      .hdr  (req_hdr),
      .idx  (widx_q),
      .word (pack_word)
   );

   mbx_req_pollcnt #(.MAX_POLLS(MAX_POLLS)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (cnt_clr),
      .inc     (cnt_inc),
      .expired (cnt_exp)
   );

   mbx_req_verdict #(.ALLOW_OLDER(ALLOW_OLDER)) u_verdict (
      .rdata     (mb_rdata),
      .exp_type  (req_type),
      .rflag     (rflag_q),
      .owned     (rsp_owned),
      .forced_ok (rsp_forced),
      .accept    (rsp_accept)
   );

   assign mb_rd_en = ((st_q == S_PRE_REQ) || (st_q == S_RSP_REQ)) && poll_tick;
   assign cnt_inc  = mb_rd_en;
   assign mb_wr_en = (st_q == S_WRITE);
   assign mb_addr  = (st_q == S_WRITE) ? widx_q : LAST_IDX;
   assign mb_wdata = pack_word;
   assign busy     = (st_q != S_IDLE);
   assign done     = (st_q == S_FIN);
   assign result   = res_q;

   always_comb begin
      st_d    = st_q;
      res_d   = res_q;
      widx_d  = widx_q;
      latch   = 1'b0;
      cnt_clr = 1'b0;
      unique case (st_q)
         S_IDLE: begin
            if (cmd_valid) begin
               latch = 1'b1;
               if ((cmd_op == OP_ESTABLISH) && vec_over) begin
                  res_d = RES_REJECT;
                  st_d  = S_FIN;
               end else begin
                  cnt_clr = 1'b1;
                  st_d    = S_PRE_REQ;
               end
            end
         end
         S_PRE_REQ: if (poll_tick) st_d = S_PRE_CHK;
         S_PRE_CHK: begin
            if (!rsp_owned) begin
               st_d   = S_WRITE;
               widx_d = (op_q == OP_ESTABLISH) ? '0 : LAST_IDX;
            end else if (cnt_exp) begin
               res_d = RES_TIMEOUT;
               st_d  = S_FIN;
            end else begin
               st_d = S_PRE_REQ;
            end
         end
         S_WRITE: begin
            if (widx_q == LAST_IDX) begin
               cnt_clr = 1'b1;
               st_d    = S_RSP_REQ;
            end else begin
               widx_d = widx_q + 1'b1;
            end
         end
         S_RSP_REQ: if (poll_tick) st_d = S_RSP_CHK;
         S_RSP_CHK: begin
            if (rsp_forced) begin
               res_d = RES_OK;
               st_d  = S_FIN;
            end else if (!rsp_owned) begin
               res_d = rsp_accept ? RES_OK : RES_PROTO;
               st_d  = S_FIN;
            end else if (cnt_exp) begin
               res_d = RES_TIMEOUT;
               st_d  = S_FIN;
            end else begin
               st_d = S_RSP_REQ;
            end
         end
         S_FIN:   st_d = S_IDLE;
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         res_q   <= RES_OK;
         widx_q  <= '0;
         op_q    <= OP_ESTABLISH;
         rflag_q <= 1'b0;
         pfns_q  <= '0;
         vec_q   <= '0;
      end else begin
         st_q   <= st_d;
         res_q  <= res_d;
         widx_q <= widx_d;
         if (latch) begin
            op_q    <= cmd_op;
            rflag_q <= cmd_reset;
            pfns_q  <= cmd_pfns;
            vec_q   <= cmd_vector[VEC_W-1:0];
         end
      end
   end

endmodule

// File: rtl/mbx_req_seq_chk.sv
module mbx_req_seq_chk #(
   parameter int WORDS = 8,
   parameter int DW    = 32
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     poll_tick,
   input logic                     busy,
   input logic                     done,
   input logic                     mb_rd_en,
   input logic                     mb_wr_en,
   input logic [$clog2(WORDS)-1:0] mb_addr,
   input logic [DW-1:0]            mb_wdata
);
   localparam int IDX_W = $clog2(WORDS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

   p_read_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mb_rd_en |-> poll_tick);

   p_read_header_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mb_rd_en |-> (mb_addr == LAST_IDX));

   p_single_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mb_rd_en && mb_wr_en));

   p_ascending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mb_wr_en && $past(mb_wr_en)) |-> (mb_addr == $past(mb_addr) + 1'b1));

   p_header_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mb_wr_en && (mb_addr == LAST_IDX)) |=> !mb_wr_en);

   p_header_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mb_wr_en && (mb_addr == LAST_IDX)) |-> (!mb_wdata[31] && !mb_wdata[7] && (mb_wdata[15:8] == 8'd0)));

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   p_access_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mb_rd_en || mb_wr_en) |-> busy);

endmodule

bind mbx_req_seq mbx_req_seq_chk #(.WORDS(WORDS), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .poll_tick (poll_tick),
   .busy      (busy),
   .done      (done),
   .mb_rd_en  (mb_rd_en),
   .mb_wr_en  (mb_wr_en),
   .mb_addr   (mb_addr),
   .mb_wdata  (mb_wdata)
);

// File: tb/mbx_req_seq_test.sv
module mbx_req_seq_test;
   localparam int MAXP = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic         cmd_op = 1'b0;
   logic         cmd_reset = 1'b0;
   logic [207:0] cmd_pfns = '0;
   logic [31:0]  cmd_vector = '0;
   logic         poll_tick = 1'b0;
   logic         busy, done;
   logic [1:0]   result;
   logic         mb_rd_en, mb_wr_en;
   logic [2:0]   mb_addr;
   logic [31:0]  mb_wdata;
   logic [31:0]  mb_rdata = '0;

   int tests = 0;
   int fails = 0;
   bit active = 0;

   // responder controls and observations
   int          pre_busy = 0, resp_after = 0;
   logic [31:0] resp_word = '0;
   logic [31:0] hdr_w = '0;
   bit          wrote = 0;
   int          rcnt = 0, pre_reads = 0, rsp_reads = 0;

   logic [31:0] exp_data[$];
   int          exp_addr[$];

   mbx_req_seq #(.MAX_POLLS(MAXP)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_reset(cmd_reset), .cmd_pfns(cmd_pfns), .cmd_vector(cmd_vector),
      .poll_tick(poll_tick), .busy(busy), .done(done), .result(result),
      .mb_rd_en(mb_rd_en), .mb_wr_en(mb_wr_en), .mb_addr(mb_addr),
      .mb_wdata(mb_wdata), .mb_rdata(mb_rdata)
   );

   always #5 clk = ~clk;

   task automatic fail(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
   endtask

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) fail(req, what, act, exp);
   endtask

   // poll tick every third cycle, driven away from the edge
   initial begin
      int t = 0;
      forever begin
         @(posedge clk);
         #1 poll_tick = (t % 3 == 0);
         t++;
      end
   end

   // mailbox responder model
   always @(posedge clk) begin
      if (!rst_n) begin
         mb_rdata <= '0; wrote <= 0; rcnt <= 0; pre_reads <= 0; rsp_reads <= 0;
      end else if (cmd_valid && !busy) begin
         wrote <= 0; rcnt <= 0; pre_reads <= 0; rsp_reads <= 0;
      end else begin
         if (mb_wr_en && mb_addr == 3'd7) begin
            wrote <= 1; rcnt <= 0; hdr_w <= mb_wdata;
         end
         if (mb_rd_en) begin
            if (!wrote) begin
               mb_rdata  <= (rcnt < pre_busy) ? 32'h8000_0000 : 32'h0;
               pre_reads <= pre_reads + 1;
            end else begin
               mb_rdata  <= (rcnt < resp_after) ? (hdr_w | 32'h8000_0000) : resp_word;
               rsp_reads <= rsp_reads + 1;
            end
            rcnt <= rcnt + 1;
         end
      end
   end

   // per-cycle comparison against the expected write stream
   always @(negedge clk) begin
      if (rst_n) begin
         if (mb_wr_en) begin
            tests++;
            if (exp_data.size() == 0) fail("R7", "unexpected write addr", 64'(mb_addr), 64'hF);
            else begin
               int a;
               logic [31:0] d;
               a = exp_addr.pop_front();
               d = exp_data.pop_front();
               if (mb_addr != a[2:0]) fail("R7", "write addr", 64'(mb_addr), 64'(a));
               else if (mb_wdata !== d) fail("R3/R4/R5/R6", $sformatf("word %0d", a), 64'(mb_wdata), 64'(d));
            end
         end
         if (mb_rd_en) begin
            tests++;
            if (!poll_tick || mb_addr != 3'd7) fail("R1", "read strobe/addr", {poll_tick, mb_addr}, 64'hF);
         end
         if (!active && (mb_rd_en || mb_wr_en || done))
            fail("R11", "activity while idle", {mb_rd_en, mb_wr_en, done}, 64'h0);
      end
   end

   // independent message packer: byte array, little-endian words
   task automatic build(input bit op, input bit rf, input logic [207:0] p, input logic [31:0] v);
      logic [7:0]  b[32];
      logic [15:0] nib;
      logic [31:0] hdr;
      for (int i = 0; i < 32; i++) b[i] = 8'h00;
      nib = '0;
      for (int q = 0; q < 4; q++) begin
         logic [51:0] f;
         f = p[q*52 +: 52];
         for (int k = 0; k < 6; k++) b[6*q+k] = f[8*k +: 8];
         nib = nib | (16'(f[51:48]) << (4*q));
      end
      b[24] = nib[7:0];  b[25] = nib[15:8];
      b[26] = v[7:0];    b[27] = v[15:8];
      hdr = (op ? 32'd2 : 32'd1) | (rf ? 32'h0100_0000 : 32'h0);
      b[28] = hdr[7:0]; b[29] = hdr[15:8]; b[30] = hdr[23:16]; b[31] = hdr[31:24];
      for (int w = 0; w < 8; w++) begin
         if (op == 1'b0 || w == 7) begin
            exp_addr.push_back(w);
            exp_data.push_back({b[4*w+3], b[4*w+2], b[4*w+1], b[4*w]});
         end
      end
   endtask

   task automatic run(input string req, input bit op, input bit rf, input logic [207:0] p,
                      input logic [31:0] v, input int pb, input int ra, input logic [31:0] rw,
                      input bit poke);
      int exp_res, exp_pre, exp_rsp;
      bit got;
      exp_data.delete(); exp_addr.delete();
      exp_pre = 0; exp_rsp = 0;
      if (op == 1'b0 && v[31:16] != 16'h0) exp_res = 3;
      else if (pb >= MAXP) begin exp_res = 1; exp_pre = MAXP; end
      else begin
         exp_pre = pb + 1;
         build(op, rf, p, v);
         if (ra >= MAXP) begin exp_res = 1; exp_rsp = MAXP; end
         else if (rf && rw == 32'hFFFF_FFFF) begin exp_res = 0; exp_rsp = ra + 1; end
         else if (rw[31]) begin exp_res = 1; exp_rsp = MAXP; end
         else begin
            exp_rsp = ra + 1;
            exp_res = (rw[2:0] == (op ? 3'd2 : 3'd1) && rw[5:3] <= 3'd0 && rw[7] && rw[15:8] == 8'd0) ? 0 : 2;
         end
      end
      pre_busy = pb; resp_after = ra; resp_word = rw;
      @(posedge clk);
      #1 cmd_valid = 1; cmd_op = op; cmd_reset = rf; cmd_pfns = p; cmd_vector = v;
      active = 1;
      @(posedge clk);
      #1 cmd_valid = 0;
      got = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (i > 0 || !done) begin
            tests++;
            if (!busy) fail("R11", "busy during command", 64'(busy), 64'h1);
         end
         if (poke && i == 3) begin cmd_valid = 1; cmd_op = ~op; cmd_vector = 32'h0; end
         if (poke && i == 4) cmd_valid = 0;
         if (done) begin got = 1; break; end
      end
      check(req, "done seen", 64'(got), 64'h1);
      check(req, "result", 64'(result), 64'(exp_res));
      check("R1/R2", "pre-send reads", 64'(pre_reads), 64'(exp_pre));
      check("R8", "response reads", 64'(rsp_reads), 64'(exp_rsp));
      check("R7", "writes left", 64'(exp_data.size()), 64'h0);
      @(negedge clk);
      active = 0;
      check("R11", "done single cycle", 64'(done), 64'h0);
      check("R11", "idle after done", 64'(busy), 64'h0);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            fail("WDOG", "watchdog expired", 64'(cyc), 64'h0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
         end
      end
   end

   initial begin
      logic [207:0] pa, pb2;
      pa  = {52'hA_1234_5678_9ABC, 52'h5_0000_0000_0001, 52'hF_FFFF_FFFF_FFFF, 52'h3_DEAD_BEEF_0042};
      pb2 = {52'h1_0203_0405_0607, 52'h8_1111_2222_3333, 52'h0_0000_0000_0000, 52'hC_CAFE_F00D_7777};
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      check("R12", "busy after reset", 64'(busy), 64'h0);
      check("R12", "done after reset", 64'(done), 64'h0);
      check("R12", "strobes after reset", {mb_rd_en, mb_wr_en}, 64'h0);

      run("R3", 1'b0, 1'b0, pa, 32'h0000_1234, 2, 3, 32'h0000_0081, 1'b0);   // R4 R6 R7
      run("R5", 1'b0, 1'b1, pb2, 32'h0000_FFFF, 0, 0, 32'h0000_0081, 1'b0);
      run("R5", 1'b0, 1'b0, pa, 32'h0001_0000, 0, 0, 32'h0, 1'b0);            // rejected
      run("R5", 1'b1, 1'b0, pa, 32'hFFFF_0000, 0, 1, 32'h0000_0082, 1'b0);    // destroy ignores vector
      run("R10", 1'b1, 1'b1, '0, 32'h0, 1, 2, 32'hFFFF_FFFF, 1'b0);
      run("R10", 1'b1, 1'b0, '0, 32'h0, 0, 1, 32'hFFFF_FFFF, 1'b0);           // owned -> timeout
      run("R2", 1'b0, 1'b0, pa, 32'h0, 20, 0, 32'h0000_0081, 1'b0);
      run("R8", 1'b1, 1'b0, '0, 32'h0, 0, 20, 32'h0000_0082, 1'b0);
      run("R9", 1'b0, 1'b0, pb2, 32'h5, 0, 1, 32'h0000_0082, 1'b0);           // wrong type
      run("R9", 1'b1, 1'b0, '0, 32'h0, 0, 1, 32'h0000_008A, 1'b0);            // version 1
      run("R9", 1'b1, 1'b0, '0, 32'h0, 0, 1, 32'h0000_0582, 1'b0);            // status 5
      run("R9", 1'b1, 1'b0, '0, 32'h0, 0, 0, 32'h0000_0002, 1'b0);            // direction 0
      run("R9", 1'b1, 1'b1, '0, 32'h0, 0, 0, 32'h0100_0082, 1'b0);            // normal accept
      run("R11", 1'b1, 1'b0, '0, 32'h0, 1, 3, 32'h0000_0082, 1'b1);           // poke while busy

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule